// File: doc/BRIEF.md
# Lockstep Redundant-Pair Fault Monitor

The block watches two redundant pairs of processing units that run in lockstep. Inside each pair a master unit produces a result and drives the shared bus when allowed. A checker unit computes the same result in parallel. The monitor compares the two results every cycle. Any difference marks that pair as faulty, and the flag stays set until software clears it.

Across the two pairs, one is primary and owns the bus, while the other shadows it and never drives. While both pairs are healthy the two roles trade places every `SWAP_PERIOD` cycles, so that a latent fault in either pair is eventually exposed on the driving side. When one pair faults, the monitor takes it off the bus and hands the bus to the healthy pair in the same cycle the flag appears. From then on rotation stops.

When both pairs are faulted, neither drives. A fatal indication is raised when both pairs show a mismatch in the same cycle. Software is told of every newly raised fault flag through a one-cycle interrupt pulse.

Top module: `lockstep_pair_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `drive_en` is 2'b01 (pair 0 primary), `pair_fault` is 0, and `fatal` and `fault_irq` are 0.
- R2: A difference between `mst_res[i]` and `chk_res[i]` sampled at a clock edge sets `pair_fault[i]` from that edge on, so the flag is visible one cycle after the compared values were presented.
- R3: A set `pair_fault[i]` stays set until a clock edge with `clr_faults` high. If that same edge also samples a mismatch on pair i, the flag stays set.
- R4: At most one bit of `drive_en` is high at any time (bit i enables pair i's master), and a pair whose fault flag is set is never enabled.
- R5: With no fault flag set, the enabled pair alternates every `SWAP_PERIOD` cycles. Pair 0 holds the bus for the first `SWAP_PERIOD` cycles after reset.
- R6: While exactly one fault flag is set, the other pair is enabled from the cycle the flag appears, and no role swap happens while it stays set.
- R7: While both fault flags are set, `drive_en` is 2'b00.
- R8: `fatal` rises one cycle after an edge at which both pairs mismatch together. It stays high until an edge with `clr_faults` and no such double mismatch. Faults arising on the two pairs in different cycles do not raise it.
- R9: `fault_irq` is high for exactly the cycles in which at least one `pair_fault` bit has just gone from 0 to 1.
- R10: After the fault flags are cleared, the enabled pair stays the pair that was healthy. The next swap comes `SWAP_PERIOD` cycles after the flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_faults | input | 1 | Software strobe that clears the fault flags and the fatal indication |
| mst_res | input | 2*DATA_W | Master results, one DATA_W slice per pair |
| chk_res | input | 2*DATA_W | Checker results, one DATA_W slice per pair |
| drive_en | output | 2 | Bus enable for each pair's master |
| pair_fault | output | 2 | Sticky fault flag per pair |
| fatal | output | 1 | Both pairs mismatched in the same cycle |
| fault_irq | output | 1 | One-cycle pulse when a fault flag is newly raised |

## Verification
The bench targets the moment of takeover. A design that waited for its role register before moving the bus would leave the bus idle for one cycle, or leave it with the faulted pair. A strobe that clears the flags in the same cycle as a fresh mismatch is driven on purpose; a design that gave the clear priority would lose that fault and skip the interrupt. Faults are also raised on the two pairs in different cycles, which must disable both pairs without raising fatal, and then on both pairs at once, which must raise it. The swap counter is watched across a clear, because a counter that kept its stale count would swap early.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef struct packed {
        logic mism;   // raw compare result this cycle
        logic flag;   // registered sticky fault
        logic nxt;    // next value of the sticky fault
    } pair_stat_t;

    // Bus enable from the registered fault flags and the rotating role.
    function automatic logic [1:0] enable_for(input logic [1:0] flt, input logic prim);
        logic [1:0] en;
        unique case (flt)
            2'b00:   en = prim ? 2'b10 : 2'b01;
            2'b01:   en = 2'b10;
            2'b10:   en = 2'b01;
            default: en = 2'b00;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/lsm_pair_cmp.sv
module lsm_pair_cmp #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [DATA_W-1:0] mst,
    input  logic [DATA_W-1:0] chk,
    output lsm_pkg::pair_stat_t stat
);
    logic mism;
    logic flag_q;
    logic flag_d;

    assign mism   = (mst != chk);
    // a fresh mismatch outranks the clear strobe
    assign flag_d = mism | (flag_q & ~clr);

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign stat.mism = mism;
    assign stat.flag = flag_q;
    assign stat.nxt  = flag_d;
endmodule

// File: rtl/lsm_role.sv
module lsm_role #(
    parameter int SWAP_PERIOD = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] flt,
    output logic       prim
);
    localparam int CNT_W = (SWAP_PERIOD > 1) ? $clog2(SWAP_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SWAP_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             prim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            prim_q <= 1'b0;
        end else begin
            unique case (flt)
                2'b01: begin cnt_q <= '0; prim_q <= 1'b1; end
                2'b10: begin cnt_q <= '0; prim_q <= 1'b0; end
                2'b11: cnt_q <= '0;
                default: begin
                    if (cnt_q == LAST) begin
                        cnt_q  <= '0;
                        prim_q <= ~prim_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign prim = prim_q;
endmodule

// File: rtl/lockstep_pair_monitor.sv
module lockstep_pair_monitor #(
    parameter int DATA_W      = 16,
    parameter int SWAP_PERIOD = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_faults,
    input  logic [1:0][DATA_W-1:0] mst_res,
    input  logic [1:0][DATA_W-1:0] chk_res,
    output logic [1:0]           drive_en,
    output logic [1:0]           pair_fault,
    output logic                 fatal,
    output logic                 fault_irq
);
    import lsm_pkg::*;

    pair_stat_t stat [2];
    logic [1:0] mism;
    logic [1:0] flt_nxt;
    logic       prim;
    logic       fatal_q;
    logic       irq_q;

    for (genvar g = 0; g < 2; g++) begin : g_pair
        lsm_pair_cmp #(.DATA_W(DATA_W)) u_cmp (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_faults),
            .mst  (mst_res[g]),
            .chk  (chk_res[g]),
            .stat (stat[g])
        );
        assign pair_fault[g] = stat[g].flag;
        assign mism[g]       = stat[g].mism;
        assign flt_nxt[g]    = stat[g].nxt;
    end

    lsm_role #(.SWAP_PERIOD(SWAP_PERIOD)) u_role (
        .clk  (clk),
        .rst  (rst),
        .flt  (pair_fault),
        .prim (prim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fatal_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            fatal_q <= (fatal_q & ~clr_faults) | (&mism);
            irq_q   <= |(flt_nxt & ~pair_fault);
        end
    end

    assign drive_en  = enable_for(pair_fault, prim);
    assign fatal     = fatal_q;
    assign fault_irq = irq_q;
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
    parameter int DATA_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   clr_faults,
    input logic [1:0][DATA_W-1:0] mst_res,
    input logic [1:0][DATA_W-1:0] chk_res,
    input logic [1:0]             drive_en,
    input logic [1:0]             pair_fault,
    input logic                   fatal,
    input logic                   fault_irq
);
    a_r4_onehot0: assert property (@(posedge clk) disable iff (rst) $onehot0(drive_en));
    a_r4_faulted_idle: assert property (@(posedge clk) disable iff (rst) (drive_en & pair_fault) == 2'b00);
    a_r7_both_off: assert property (@(posedge clk) disable iff (rst) (&pair_fault) |-> drive_en == 2'b00);
    a_r6_takeover_b: assert property (@(posedge clk) disable iff (rst) pair_fault == 2'b01 |-> drive_en == 2'b10);
    a_r6_takeover_a: assert property (@(posedge clk) disable iff (rst) pair_fault == 2'b10 |-> drive_en == 2'b01);
    a_r2_flag0: assert property (@(posedge clk) disable iff (rst) (mst_res[0] != chk_res[0]) |=> pair_fault[0]);
    a_r2_flag1: assert property (@(posedge clk) disable iff (rst) (mst_res[1] != chk_res[1]) |=> pair_fault[1]);
    a_r3_sticky0: assert property (@(posedge clk) disable iff (rst) (pair_fault[0] && !clr_faults) |=> pair_fault[0]);
    a_r3_sticky1: assert property (@(posedge clk) disable iff (rst) (pair_fault[1] && !clr_faults) |=> pair_fault[1]);
    a_r8_fatal: assert property (@(posedge clk) disable iff (rst)
        ((mst_res[0] != chk_res[0]) && (mst_res[1] != chk_res[1])) |=> fatal);
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst) ($rose(pair_fault[0]) || $rose(pair_fault[1])) |-> fault_irq);
endmodule

bind lockstep_pair_monitor lsm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_faults (clr_faults),
    .mst_res    (mst_res),
    .chk_res    (chk_res),
    .drive_en   (drive_en),
    .pair_fault (pair_fault),
    .fatal      (fatal),
    .fault_irq  (fault_irq)
);

// File: tb/sim_lockstep_pair_monitor.sv
module sim_lockstep_pair_monitor;
    localparam int DW = 16;
    localparam int NP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_faults = 1'b0;
    logic [1:0][DW-1:0] mst_res = '0;
    logic [1:0][DW-1:0] chk_res = '0;
    logic [1:0] drive_en;
    logic [1:0] pair_fault;
    logic fatal;
    logic fault_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit f0, f1, m_fatal, m_irq, m_prim;
    int m_cnt;
    logic [15:0] lfsr = 16'hACE1;
    string phase = "R1";

    always #2.5 clk = ~clk;

    lockstep_pair_monitor #(.DATA_W(DW), .SWAP_PERIOD(NP)) u0 (
        .clk(clk), .rst(rst), .clr_faults(clr_faults),
        .mst_res(mst_res), .chk_res(chk_res),
        .drive_en(drive_en), .pair_fault(pair_fault),
        .fatal(fatal), .fault_irq(fault_irq)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_en();
        if (f0 && f1) return 2'b00;
        if (f0) return 2'b10;
        if (f1) return 2'b01;
        return m_prim ? 2'b10 : 2'b01;
    endfunction

    task automatic model_step(input bit mm0, input bit mm1);
        bit n0, n1;
        if (rst) begin
            f0 = 0; f1 = 0; m_fatal = 0; m_irq = 0; m_prim = 0; m_cnt = 0;
            return;
        end
        if (f0 != f1) begin
            m_prim = f0;   // healthy pair becomes primary
            m_cnt = 0;
        end else if (f0 && f1) begin
            m_cnt = 0;
        end else if (m_cnt == NP - 1) begin
            m_cnt = 0;
            m_prim = !m_prim;
        end else begin
            m_cnt++;
        end
        n0 = mm0 || (f0 && !clr_faults);
        n1 = mm1 || (f1 && !clr_faults);
        m_irq = (n0 && !f0) || (n1 && !f1);
        m_fatal = (m_fatal && !clr_faults) || (mm0 && mm1);
        f0 = n0; f1 = n1;
    endtask

    // one clock: drive, edge, model, compare away from the edge
    task automatic cyc(input bit mm0, input bit mm1, input bit clr);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mst_res[0] = lfsr;
        mst_res[1] = ~lfsr;
        chk_res[0] = mm0 ? (lfsr ^ 16'h0100) : lfsr;
        chk_res[1] = mm1 ? (~lfsr ^ 16'h0001) : ~lfsr;
        clr_faults = clr;
        @(posedge clk);
        model_step(mm0, mm1);
        @(negedge clk);
        check({phase, " drive_en"}, drive_en, exp_en());
        check("R2/R3 pair_fault", pair_fault, {f1, f0});
        check("R8 fatal", {1'b0, fatal}, {1'b0, m_fatal});
        check("R9 fault_irq", {1'b0, fault_irq}, {1'b0, m_irq});
        checks++;
        if ($countones(drive_en) > 1 || (drive_en & pair_fault) != 2'b00) begin
            errors++;
            $display("FAIL R4 actual drive_en=%b fault=%b expected one-hot-or-zero, no faulted pair", drive_en, pair_fault);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        phase = "R1";
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        rst = 1'b0;
        // first cycle out of reset must still show R1 state
        cyc(0, 0, 0);
        check("R1 drive_en after reset", drive_en, 2'b01);
        check("R1 flags after reset", pair_fault, 2'b00);

        // R5: rotation with healthy pairs
        phase = "R5";
        idle(3 * NP + 3);

        // R2, R6, R9: single-cycle mismatch on pair 1
        phase = "R6";
        cyc(0, 1, 0);
        check("R2 flag one cycle later", pair_fault, 2'b10);
        check("R9 irq pulse", {1'b0, fault_irq}, 2'b01);
        check("R6 pair 0 takes the bus", drive_en, 2'b01);
        idle(2 * NP + 1);   // no swaps while faulted
        check("R3 flag still held", pair_fault, 2'b10);

        // R10: clear, rotation restarts from pair 0
        phase = "R10";
        cyc(0, 0, 1);
        check("R10 flags cleared", pair_fault, 2'b00);
        idle(2 * NP + 2);

        // R3: clear together with fresh mismatch keeps the flag
        phase = "R6";
        cyc(1, 0, 0);
        check("R6 pair 1 takes the bus", drive_en, 2'b10);
        cyc(1, 0, 1);
        check("R3 clear loses to new mismatch", pair_fault, 2'b01);
        check("R9 no irq on held flag", {1'b0, fault_irq}, 2'b00);
        idle(3);

        // R7, R8: second pair faults later: both off, no fatal
        phase = "R7";
        cyc(0, 1, 0);
        check("R7 both faulted bus idle", drive_en, 2'b00);
        check("R8 no fatal for staggered faults", {1'b0, fatal}, 2'b00);
        idle(4);

        // R8: simultaneous mismatch raises fatal
        cyc(0, 0, 1);
        phase = "R7";
        cyc(1, 1, 0);
        check("R8 fatal raised", {1'b0, fatal}, 2'b01);
        idle(3);
        check("R8 fatal sticky", {1'b0, fatal}, 2'b01);
        phase = "R10";
        cyc(0, 0, 1);
        check("R8 fatal cleared", {1'b0, fatal}, 2'b00);
        idle(2 * NP + 3);

        // R5 again with mismatch on the shadow mid-rotation
        phase = "R6";
        cyc(1, 0, 0);
        idle(5);
        phase = "R10";
        cyc(0, 0, 1);
        idle(NP + 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule